// File: doc/BRIEF.md
# Completion Interrupt Coalescing Unit

This block sits beside a task-completion source and reduces the number of interrupts the host sees. Each completion arrives as a one-cycle pulse with a flag. When the flag marks the task as urgent, the completion raises an interrupt straight away. Completions without the flag are deferred. A deferred completion is held back until one of two triggers fires. The first trigger is a counter that reaches a programmed threshold. The second is a coarse timer that reaches a programmed timeout.

Software sees one 32-bit control word, written through a simple write strobe and read back at any time. The word holds the master enable, a read-only status bit, the count threshold and the timeout value. The threshold and the timeout each have their own write-enable qualifier, so one field can be changed without disturbing the other. A self-clearing command bit resets the counter, the timer and the pending coalesced interrupt. Software normally sets this bit in its interrupt service routine.

The timer advances on a tick input. One timeout unit is `PRESCALE` ticks, which is 1024 by default.

Top module: `intr_coalesce`

## Requirements
- R1: A completion with `cmpl_urgent`=1 sets `irq` in the following cycle, whatever the enable bit holds.
- R2: While the enable bit (bit 31) is 0, deferred completions are not counted and do not start or advance the timer, so no coalesced interrupt is raised.
- R3: Only completions with `cmpl_urgent`=0 increment the counter. The counter never increments past the threshold value.
- R4: A threshold of 0 stops the counter from incrementing and produces no count-based interrupt.
- R5: The timer starts on the first deferred completion after a clear. It raises the coalesced interrupt once its unit count reaches the timeout value. It then stops, and later completions do not restart it until the next clear.
- R6: One timeout unit is `PRESCALE` cycles on which `tick` is high, counted from the cycle after the timer starts. A timeout value of 0 keeps the timer from advancing.
- R7: Read-only bit 20 reads 1 exactly when the counter is nonzero.
- R8: A write updates the threshold (bits 12:8) only when bit 15 is set in the same write. It updates the timeout (bits 6:0) only when bit 7 is set. Bits 15 and 7 always read as 0.
- R9: After reset the control word reads 0. Only bits 31, 20, 12:8 and 6:0 can ever read nonzero.
- R10: The coalesced interrupt is set in the cycle after the counter reaches a nonzero threshold or the timer expires. It then holds `irq` high until a clear.
- R11: Writing 1 to bit 16 clears the counter, the timer, its prescaler and the pending coalesced interrupt. The bit reads as 0. A completion in the same cycle as the clear is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word and status |
| cmpl_valid | input | 1 | One-cycle task-completion pulse |
| cmpl_urgent | input | 1 | The completing task asks for an immediate interrupt |
| tick | input | 1 | Timer clock tick, one cycle wide |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the write strobe, the completion pulse and the tick are synchronous and free of X after reset. They also assume that a threshold the software lowers below the current count is followed by a clear before counting resumes. The stimulus always raises the threshold from zero or from a cleared state. Inputs change only on falling edges, so every value sampled at a rising edge is stable. Ticks come either on every cycle or on every other cycle, which exercises the prescaler at both rates.

// File: rtl/coal_pkg.sv
package coal_pkg;

    // Control word layout; software decodes these positions.
    localparam int unsigned BIT_ENABLE  = 31;
    localparam int unsigned BIT_STATUS  = 20;
    localparam int unsigned BIT_CLEAR   = 16;
    localparam int unsigned BIT_THR_WEN = 15;
    localparam int unsigned THR_LSB     = 8;
    localparam int unsigned BIT_TOV_WEN = 7;
    localparam int unsigned TOV_LSB     = 0;

    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_RUN  = 2'd1,
        TMR_DONE = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/coal_regs.sv
module coal_regs
    import coal_pkg::*;
#(
    parameter int unsigned CNT_W = 5,
    parameter int unsigned TO_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [31:0]      wdata,
    input  logic             cnt_nz,
    output logic             en,
    output logic [CNT_W-1:0] thr,
    output logic [TO_W-1:0]  tov,
    output logic             clr,
    output logic [31:0]      rdata
);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] thr;
        logic [TO_W-1:0]  tov;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            r_d.en = wdata[BIT_ENABLE];
            if (wdata[BIT_THR_WEN]) begin
                r_d.thr = wdata[THR_LSB +: CNT_W];
            end
            if (wdata[BIT_TOV_WEN]) begin
                r_d.tov = wdata[TOV_LSB +: TO_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata                      = '0;
        rdata[BIT_ENABLE]          = r_q.en;
        rdata[BIT_STATUS]          = cnt_nz;
        rdata[THR_LSB +: CNT_W]    = r_q.thr;
        rdata[TOV_LSB +: TO_W]     = r_q.tov;
    end

    assign en  = r_q.en;
    assign thr = r_q.thr;
    assign tov = r_q.tov;
    assign clr = wr & wdata[BIT_CLEAR];

endmodule

// File: rtl/coal_counter.sv
module coal_counter #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] thr,
    input  logic             defer_evt,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;
    logic inc;

    always_comb begin
        c_d = c_q;
        inc = 1'b0;
        hit = 1'b0;
        if (clr) begin
            c_d.cnt = '0;
        end else if (en && defer_evt && (thr != '0) && (c_q.cnt < thr)) begin
            inc     = 1'b1;
            c_d.cnt = c_q.cnt + 1'b1;
            hit     = (c_d.cnt == thr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt = c_q.cnt;

endmodule

// File: rtl/coal_prescale.sv
module coal_prescale #(
    parameter int unsigned PRESCALE = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic wrap
);

    localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign wrap = adv;
        end else begin : g_count
            typedef struct packed {
                logic [PS_W-1:0] ps;
            } ps_t;

            ps_t p_d, p_q;

            always_comb begin
                p_d  = p_q;
                wrap = 1'b0;
                if (clr) begin
                    p_d.ps = '0;
                end else if (adv) begin
                    if (p_q.ps == PS_LAST) begin
                        p_d.ps = '0;
                        wrap   = 1'b1;
                    end else begin
                        p_d.ps = p_q.ps + 1'b1;
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    p_q <= '0;
                end else begin
                    p_q <= p_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/coal_timer.sv
module coal_timer
    import coal_pkg::*;
#(
    parameter int unsigned TO_W     = 7,
    parameter int unsigned PRESCALE = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [TO_W-1:0] tov,
    input  logic            defer_evt,
    input  logic            tick,
    output logic            expire,
    output logic            running
);

    typedef struct packed {
        tmr_state_e      st;
        logic [TO_W-1:0] units;
    } tmr_t;

    tmr_t t_d, t_q;
    logic adv;
    logic unit_wrap;
    logic [TO_W:0] units_nxt;

    assign adv = en && (t_q.st == TMR_RUN) && (tov != '0) && tick && !clr;

    coal_prescale #(
        .PRESCALE (PRESCALE)
    ) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr || (t_q.st != TMR_RUN)),
        .adv   (adv),
        .wrap  (unit_wrap)
    );

    always_comb begin
        t_d       = t_q;
        expire    = 1'b0;
        units_nxt = {1'b0, t_q.units} + 1'b1;
        if (clr) begin
            t_d.st    = TMR_IDLE;
            t_d.units = '0;
        end else if (en) begin
            unique case (t_q.st)
                TMR_IDLE: begin
                    if (defer_evt && (tov != '0)) begin
                        t_d.st    = TMR_RUN;
                        t_d.units = '0;
                    end
                end
                TMR_RUN: begin
                    if (unit_wrap) begin
                        t_d.units = units_nxt[TO_W-1:0];
                        if (units_nxt >= {1'b0, tov}) begin
                            t_d.st = TMR_DONE;
                            expire = 1'b1;
                        end
                    end
                end
                default: begin
                    t_d.st = TMR_DONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{st: TMR_IDLE, units: '0};
        end else begin
            t_q <= t_d;
        end
    end

    assign running = (t_q.st == TMR_RUN);

endmodule

// File: rtl/intr_coalesce.sv
module intr_coalesce
    import coal_pkg::*;
#(
    parameter int unsigned CNT_W    = 5,
    parameter int unsigned TO_W     = 7,
    parameter int unsigned PRESCALE = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cmpl_valid,
    input  logic        cmpl_urgent,
    input  logic        tick,
    output logic        irq
);

    typedef struct packed {
        logic imm;
        logic pend;
    } irq_t;

    irq_t i_d, i_q;

    logic             en_w;
    logic [CNT_W-1:0] thr_w;
    logic [TO_W-1:0]  tov_w;
    logic             clr_w;
    logic [CNT_W-1:0] cnt_w;
    logic             hit_w;
    logic             expire_w;
    logic             running_w;
    logic             defer_w;
    logic             coal_pend;

    assign defer_w = cmpl_valid & ~cmpl_urgent;

    coal_regs #(
        .CNT_W (CNT_W),
        .TO_W  (TO_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .cnt_nz (cnt_w != '0),
        .en     (en_w),
        .thr    (thr_w),
        .tov    (tov_w),
        .clr    (clr_w),
        .rdata  (reg_rdata)
    );

    coal_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_w),
        .en        (en_w),
        .thr       (thr_w),
        .defer_evt (defer_w),
        .cnt       (cnt_w),
        .hit       (hit_w)
    );

    coal_timer #(
        .TO_W     (TO_W),
        .PRESCALE (PRESCALE)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_w),
        .en        (en_w),
        .tov       (tov_w),
        .defer_evt (defer_w),
        .tick      (tick),
        .expire    (expire_w),
        .running   (running_w)
    );

    always_comb begin
        i_d     = i_q;
        i_d.imm = cmpl_valid & cmpl_urgent;
        if (clr_w) begin
            i_d.pend = 1'b0;
        end else if (hit_w || expire_w) begin
            i_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assign coal_pend = i_q.pend;
    assign irq       = i_q.imm | i_q.pend;

endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             cmpl_valid,
    input logic             cmpl_urgent,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic             pend
);

    logic clr_req;
    assign clr_req = reg_wr & reg_wdata[16];

    AST_URGENT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && cmpl_urgent) |=> irq); // R1

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[31] && !clr_req) |=> (cnt == $past(cnt))); // R2

    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == reg_rdata[12:8]) && !clr_req) |=> (cnt == $past(cnt))); // R3

    AST_ZERO_THR: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rdata[12:8] == '0) && !clr_req) |=> (cnt == $past(cnt))); // R4

    AST_STATUS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[20] == (cnt != '0)); // R7

    AST_THR_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[15]) |=> (reg_rdata[12:8] == $past(reg_rdata[12:8]))); // R8

    AST_TOV_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[7]) |=> (reg_rdata[6:0] == $past(reg_rdata[6:0]))); // R8

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[30:21] == '0) && (reg_rdata[19:13] == '0) && !reg_rdata[7]); // R9

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_req) |=> (pend && irq)); // R10

    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (!pend && (cnt == '0))); // R11

endmodule

bind intr_coalesce coal_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .cmpl_valid  (cmpl_valid),
    .cmpl_urgent (cmpl_urgent),
    .irq         (irq),
    .cnt         (cnt_w),
    .pend        (coal_pend)
);

// File: tb/intr_coalesce_tb.sv
module intr_coalesce_tb;

    localparam int PS = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmpl_valid = 1'b0;
    logic        cmpl_urgent = 1'b0;
    logic        tick = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int tick_mode = 0;  // 0 none, 1 every cycle, 2 every other cycle
    int cyc_cnt = 0;
    bit done = 0;

    // behavioural reference state
    int m_en, m_thr, m_tov, m_cnt, m_tstate, m_units, m_ps, m_pend, m_imm;

    always #5 clk = ~clk;

    intr_coalesce #(.PRESCALE(PS)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cmpl_valid  (cmpl_valid),
        .cmpl_urgent (cmpl_urgent),
        .tick        (tick),
        .irq         (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_rdata();
        logic [31:0] r = '0;
        r[31]   = (m_en != 0);
        r[20]   = (m_cnt != 0);
        r[12:8] = m_thr[4:0];
        r[6:0]  = m_tov[6:0];
        return r;
    endfunction

    // reference model: updated on each rising edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_thr = 0; m_tov = 0; m_cnt = 0; m_tstate = 0;
            m_units = 0; m_ps = 0; m_pend = 0; m_imm = 0;
        end else begin
            bit defer;
            m_imm = (cmpl_valid && cmpl_urgent) ? 1 : 0;
            defer = cmpl_valid && !cmpl_urgent && (m_en != 0);
            if (reg_wr && reg_wdata[16]) begin
                m_cnt = 0; m_tstate = 0; m_units = 0; m_ps = 0; m_pend = 0;
            end else begin
                if (defer && m_thr != 0 && m_cnt < m_thr) begin
                    m_cnt++;
                    if (m_cnt == m_thr) m_pend = 1;
                end
                if (m_tstate == 1 && m_en != 0 && m_tov != 0 && tick) begin
                    m_ps++;
                    if (m_ps == PS) begin
                        m_ps = 0;
                        m_units++;
                        if (m_units >= m_tov) begin
                            m_tstate = 2;
                            m_pend = 1;
                        end
                    end
                end else if (m_tstate == 0 && defer && m_tov != 0) begin
                    m_tstate = 1; m_units = 0; m_ps = 0;
                end
            end
            if (reg_wr) begin
                m_en = reg_wdata[31];
                if (reg_wdata[15]) m_thr = reg_wdata[12:8];
                if (reg_wdata[7])  m_tov = reg_wdata[6:0];
            end
        end
    end

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("MODEL irq (R1 R10)", {31'b0, irq}, {31'b0, (m_imm != 0 || m_pend != 0)});
            chk("MODEL rdata (R7 R9)", reg_rdata, model_rdata());
        end
    end

    always @(negedge clk) begin
        if (tick_mode == 1) tick <= 1'b1;
        else if (tick_mode == 2) tick <= ~tick;
        else tick <= 1'b0;
    end

    // watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc_cnt);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        cyc(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic cmpl(input logic urg);
        cmpl_valid = 1'b1; cmpl_urgent = urg;
        cyc(1);
        cmpl_valid = 1'b0; cmpl_urgent = 1'b0;
    endtask

    function automatic logic [31:0] ctl(input bit en, input int thr, input int tov, input bit clr);
        logic [31:0] w = '0;
        w[31] = en; w[16] = clr;
        w[15] = 1'b1; w[12:8] = thr[4:0];
        w[7] = 1'b1; w[6:0] = tov[6:0];
        return w;
    endfunction

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R9 reset rdata", reg_rdata, 32'h0);
        chk("R9 reset irq", {31'b0, irq}, 32'h0);

        // R8/R9: field placement and write-enable qualifiers
        wr(ctl(1, 3, 0, 0));
        chk("R9 fields readback", reg_rdata, 32'h8000_0300);
        wr(32'h8000_1F05);            // bits 15 and 7 clear
        chk("R8 no wen keeps fields", reg_rdata, 32'h8000_0300);
        wr(32'h8000_8A00);            // threshold wen only, value 10
        chk("R8 thr wen, wen bit reads 0", reg_rdata, 32'h8000_0A00);

        // R1: urgent completion with coalescing disabled
        wr(32'h0000_0000);
        cmpl(1);
        chk("R1 urgent irq when disabled", {31'b0, irq}, 32'h1);
        cyc(1);
        chk("R1 urgent irq is one cycle", {31'b0, irq}, 32'h0);

        // R2: disabled -> deferred completions ignored
        wr(32'h0000_8300);            // thr=3, enable 0
        repeat (4) cmpl(0);
        cyc(1);
        chk("R2 disabled no count", reg_rdata, 32'h0000_0300);
        chk("R2 disabled no irq", {31'b0, irq}, 32'h0);

        // R3/R7/R10: counting to threshold 3
        wr(ctl(1, 3, 0, 1));
        cmpl(0);
        chk("R7 status after one", {31'b0, reg_rdata[20]}, 32'h1);
        cmpl(1);
        cyc(1);
        chk("R3 urgent not counted", {31'b0, irq}, 32'h0);
        cmpl(0);
        chk("R3 two deferred no irq", {31'b0, irq}, 32'h0);
        cmpl(0);
        chk("R10 irq at threshold", {31'b0, irq}, 32'h1);
        repeat (3) cmpl(0);
        cyc(5);
        chk("R10 irq held", {31'b0, irq}, 32'h1);

        // R11: clear, and clear beats a simultaneous completion
        wr(ctl(1, 3, 0, 1));
        chk("R11 clear drops irq", {31'b0, irq}, 32'h0);
        chk("R11 clear zeroes status", {31'b0, reg_rdata[20]}, 32'h0);
        cmpl_valid = 1'b1;
        wr(ctl(1, 3, 0, 1));
        cmpl_valid = 1'b0;
        chk("R11 clear wins over completion", {31'b0, reg_rdata[20]}, 32'h0);

        // R4: zero threshold
        wr(ctl(1, 0, 0, 1));
        repeat (40) cmpl(0);
        cyc(1);
        chk("R4 zero thr no count", {31'b0, reg_rdata[20]}, 32'h0);
        chk("R4 zero thr no irq", {31'b0, irq}, 32'h0);

        // R5/R6: timer with one unit, tick every cycle
        tick_mode = 1;
        wr(ctl(1, 0, 1, 1));
        cmpl(0);
        cyc(PS - 1);
        chk("R6 no expiry before one unit", {31'b0, irq}, 32'h0);
        cyc(1);
        chk("R5 expiry after one unit", {31'b0, irq}, 32'h1);

        // R5: timer stays stopped after expiry until clear
        wr(ctl(1, 0, 1, 1));
        cyc(3);
        cmpl(0);
        cyc(PS - 1);
        chk("R5 restarted after clear, not yet", {31'b0, irq}, 32'h0);
        cyc(1);
        chk("R5 restarted after clear expires", {31'b0, irq}, 32'h1);

        // R6: zero timeout keeps timer stopped
        wr(ctl(1, 0, 0, 1));
        cmpl(0);
        cyc(PS + 100);
        chk("R6 zero timeout no irq", {31'b0, irq}, 32'h0);

        // R2: disabled timer does not run
        wr(32'h0001_8081);            // enable 0, tov=1, thr=0, clear
        cmpl(0);
        cyc(PS + 100);
        chk("R2 disabled timer idle", {31'b0, irq}, 32'h0);

        // R6: half-rate ticks, two units
        tick_mode = 2;
        wr(ctl(1, 0, 2, 1));
        cmpl(0);
        cyc(3 * PS);
        chk("R6 half rate not yet", {31'b0, irq}, 32'h0);
        cyc(PS + 4);
        chk("R6 half rate expiry", {31'b0, irq}, 32'h1);

        // R10: count trigger and timer together, count wins first
        tick_mode = 1;
        wr(ctl(1, 2, 5, 1));
        cmpl(0);
        cmpl(0);
        chk("R10 count before timeout", {31'b0, irq}, 32'h1);
        wr(ctl(1, 2, 5, 1));
        chk("R11 clear of mixed", {31'b0, irq}, 32'h0);
        cyc(5);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule